// File: doc/BRIEF.md
# Dual-Copy ECC Memory Arbiter

This block stores every word twice. A single shared encoder turns a 16-bit data word into a 22-bit single-error-correcting, double-error-detecting codeword. The same codeword is written into two independent memory copies, A and B. On a read, each copy is decoded by its own decoder. Each decoder reports two flags: a nonzero-syndrome flag and an overall-parity-mismatch flag. It also produces a corrected data word.

A small combinational arbiter looks at both flag pairs and picks the copy whose data goes to the output. A clean copy always wins. Otherwise a copy with odd parity mismatch (correctable) wins over one that shows an even-weight error. When both copies show an even-weight error, the read is flagged uncorrectable.

With this rule, any spread of up to three flipped bits over the two copies still returns the written data. Read data, the copy selects and the uncorrectable flag are registered, so a read request returns its result on the second clock edge after it is sampled.

Two error-mask inputs are XORed into the codeword of each copy on a write. They give the environment a way to place soft errors in stored words.

Top module: `dual_copy_ecc_mem`

## Requirements
- R1: A write with `wr_en` stores the encoded word of `wr_data` at `addr` in both copies, each XORed with its own mask (`inj_a`, `inj_b`); the masks have no effect when `wr_en` is low. Codeword layout: bit 0 is even parity over bits 21..1, bits 1, 2, 4, 8 and 16 are check bits, and data bit k sits in the k-th remaining position in ascending order.
- R2: `rd_valid` is high exactly two clock edges after an `rd_en` sampled high, and is low otherwise; reset clears `rd_valid`, `sel_a`, `sel_b` and `uncorrectable`.
- R3: At most one of `sel_a` and `sel_b` is high. When `rd_valid` is high, exactly one of `sel_a`, `sel_b`, `uncorrectable` is high. When `rd_valid` is low, all three are low.
- R4: When neither copy shows an error, copy A is selected.
- R5: A clean copy is selected over the other copy whatever that copy shows. This includes a three-error copy whose flags look like a single error.
- R6: When both copies show a parity mismatch (one or three flips each), copy A is selected and its corrected data is returned.
- R7: When one copy shows a parity mismatch and the other shows a nonzero syndrome with matching parity, the parity-mismatch copy is selected.
- R8: When both copies show a nonzero syndrome with matching parity, `uncorrectable` is raised and neither select is high.
- R9: For every pattern of at most three flipped bits in total across the two copies, `rd_data` equals the written word and `uncorrectable` stays low.
- R10: A read and a write to the same address in the same cycle return the previously stored word; the next read returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address shared by read and write |
| wr_en | input | 1 | Write request |
| wr_data | input | 16 | Data word to store |
| inj_a | input | 22 | Bit-flip mask applied to copy A on write |
| inj_b | input | 22 | Bit-flip mask applied to copy B on write |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Corrected data from the selected copy |
| sel_a | output | 1 | Copy A supplied the read data |
| sel_b | output | 1 | Copy B supplied the read data |
| uncorrectable | output | 1 | Neither copy can be trusted |

## Verification
A write and a read can hit the same address in the same cycle, and the memory must then hand back the old word. The bench provokes this by raising `wr_en` and `rd_en` together on one address. It judges the result by the old data coming out two edges later and the new data coming out on the following read. Error placement and copy selection are exercised exhaustively: every mask of zero to three flips over the 44 stored bits is written, read back, and compared with a pick predicted from the flip count in each copy.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int DATA_W = 16;
    localparam int NCOPY  = 2;

    // smallest check count r with 2^r >= DATA_W + r + 1
    function automatic int hamming_checks(input int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    localparam int SYN_W = hamming_checks(DATA_W);
    localparam int CW_W  = DATA_W + SYN_W + 1;

    typedef struct packed {
        logic syn_nz;   // syndrome nonzero
        logic par;      // overall parity mismatch
    } sig_t;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_A    = 2'd1,
        PICK_B    = 2'd2
    } pick_e;

    function automatic logic is_pow2(input int i);
        return (i & (i - 1)) == 0;
    endfunction

    function automatic logic [CW_W-1:0] cw_pack(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0]  w;
        logic [SYN_W-1:0] acc;
        int k;
        w   = '0;
        acc = '0;
        k   = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                w[i] = d[k];
                if (d[k]) acc ^= SYN_W'(i);
                k++;
            end
        end
        for (int j = 0; j < SYN_W; j++) w[1 << j] = acc[j];
        w[0] = ^w[CW_W-1:1];
        return w;
    endfunction

    function automatic logic [SYN_W-1:0] cw_syndrome(input logic [CW_W-1:0] w);
        logic [SYN_W-1:0] acc;
        acc = '0;
        for (int i = 1; i < CW_W; i++) begin
            if (w[i]) acc ^= SYN_W'(i);
        end
        return acc;
    endfunction

    function automatic logic [CW_W-1:0] cw_fix(input logic [CW_W-1:0] w,
                                               input logic [SYN_W-1:0] s,
                                               input logic p);
        logic [CW_W-1:0] r;
        r = w;
        if (p && (s != '0) && (int'(s) < CW_W)) r[s] = ~r[s];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] cw_unpack(input logic [CW_W-1:0] w);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                d[k] = w[i];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dcm_encoder.sv
module dcm_encoder import dcm_pkg::*; (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    always_comb cw_o = cw_pack(data_i);
endmodule

// File: rtl/dcm_store.sv
module dcm_store import dcm_pkg::*; #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW_W-1:0]   wdata,
    output logic [CW_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW_W-1:0] mem [DEPTH];

    // read-before-write on a shared address
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[addr];
        if (we) mem[addr] <= wdata;
    end
endmodule

// File: rtl/dcm_decoder.sv
module dcm_decoder import dcm_pkg::*; (
    input  logic [CW_W-1:0]   cw_i,
    output sig_t              sig_o,
    output logic [DATA_W-1:0] data_o
);
    logic [SYN_W-1:0] syn;
    logic             pmis;

    always_comb begin
        syn          = cw_syndrome(cw_i);
        pmis         = ^cw_i;
        sig_o.syn_nz = |syn;
        sig_o.par    = pmis;
        data_o       = cw_unpack(cw_fix(cw_i, syn, pmis));
    end
endmodule

// File: rtl/dcm_arbiter.sv
module dcm_arbiter import dcm_pkg::*; (
    input  sig_t  sig_a,
    input  sig_t  sig_b,
    output pick_e pick
);
    logic a_clean, b_clean;

    always_comb begin
        a_clean = !sig_a.syn_nz && !sig_a.par;
        b_clean = !sig_b.syn_nz && !sig_b.par;
        if (a_clean)        pick = PICK_A;
        else if (b_clean)   pick = PICK_B;
        else if (sig_a.par) pick = PICK_A;
        else if (sig_b.par) pick = PICK_B;
        else                pick = PICK_NONE;
    end
endmodule

// File: rtl/dual_copy_ecc_mem.sv
module dual_copy_ecc_mem import dcm_pkg::*; #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW_W-1:0]   inj_a,
    input  logic [CW_W-1:0]   inj_b,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sel_a,
    output logic              sel_b,
    output logic              uncorrectable
);
    logic [CW_W-1:0]   enc_cw;
    logic [CW_W-1:0]   inj    [NCOPY];
    logic [CW_W-1:0]   rd_cw  [NCOPY];
    sig_t              sig    [NCOPY];
    logic [DATA_W-1:0] fixed  [NCOPY];
    logic [NCOPY-1:0]  flag_nz;
    logic [NCOPY-1:0]  flag_par;
    pick_e             pick;
    logic              mem_vld;

    assign inj[0] = inj_a;
    assign inj[1] = inj_b;

    dcm_encoder u_enc (.data_i(wr_data), .cw_o(enc_cw));

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        dcm_store #(.ADDR_W(ADDR_W)) u_mem (
            .clk   (clk),
            .we    (wr_en),
            .re    (rd_en),
            .addr  (addr),
            .wdata (enc_cw ^ inj[c]),
            .rdata (rd_cw[c])
        );
        dcm_decoder u_dec (
            .cw_i   (rd_cw[c]),
            .sig_o  (sig[c]),
            .data_o (fixed[c])
        );
        assign flag_nz[c]  = sig[c].syn_nz;
        assign flag_par[c] = sig[c].par;
    end

    dcm_arbiter u_arb (.sig_a(sig[0]), .sig_b(sig[1]), .pick(pick));

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_vld       <= 1'b0;
            rd_valid      <= 1'b0;
            sel_a         <= 1'b0;
            sel_b         <= 1'b0;
            uncorrectable <= 1'b0;
            rd_data       <= '0;
        end else begin
            mem_vld       <= rd_en;
            rd_valid      <= mem_vld;
            sel_a         <= mem_vld && (pick == PICK_A);
            sel_b         <= mem_vld && (pick == PICK_B);
            uncorrectable <= mem_vld && (pick == PICK_NONE);
            if (mem_vld) rd_data <= (pick == PICK_B) ? fixed[1] : fixed[0];
        end
    end
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       rd_valid,
    input logic       sel_a,
    input logic       sel_b,
    input logic       unc,
    input logic [1:0] flag_nz,
    input logic [1:0] flag_par
);
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_a, sel_b}));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!sel_a && !sel_b && !unc));

    p_one_result_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $onehot({sel_a, sel_b, unc}));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> ##2 rd_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en, 2));

    p_both_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(flag_nz == 2'b00 && flag_par == 2'b00)) |-> sel_a);

    p_clean_b_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(!flag_nz[1] && !flag_par[1] && (flag_nz[0] || flag_par[0]))) |-> sel_b);

    p_both_odd_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(flag_par == 2'b11)) |-> sel_a);

    p_odd_over_even_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(flag_par == 2'b10 && flag_nz[0])) |-> sel_b);

    p_both_even_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(flag_nz == 2'b11 && flag_par == 2'b00)) |-> unc);
endmodule

bind dual_copy_ecc_mem dcm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .unc      (uncorrectable),
    .flag_nz  (flag_nz),
    .flag_par (flag_par)
);

// File: tb/dual_copy_ecc_mem_test.sv
module dual_copy_ecc_mem_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [21:0] inj_a = '0;
    logic [21:0] inj_b = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sel_a, sel_b, uncorrectable;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    int  pat = 0;

    always #2 clk = ~clk;

    dual_copy_ecc_mem #(.ADDR_W(4)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .inj_a(inj_a), .inj_b(inj_b), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .sel_a(sel_a), .sel_b(sel_b),
        .uncorrectable(uncorrectable)
    );

    // {mask A, mask B, expected {sel_a, sel_b, uncorrectable}}
    localparam logic [46:0] VEC [8] = '{
        {22'h000000, 22'h000000, 3'b100},   // R4 both clean
        {22'h000020, 22'h000000, 3'b010},   // R5 single in A, B clean
        {22'h000248, 22'h000000, 3'b010},   // R5 three in A look single
        {22'h000000, 22'h008100, 3'b100},   // R5 A clean, B double
        {22'h000080, 22'h001000, 3'b100},   // R6 single in both
        {22'h000004, 22'h000402, 3'b100},   // R7 A single, B double
        {22'h000018, 22'h000001, 3'b010},   // R7 A double, B parity bit
        {22'h000030, 22'h000300, 3'b001}    // R8 double in both
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] predict(input int ca, input int cb);
        if (ca == 0)           return 3'b100;
        if (cb == 0)           return 3'b010;
        if (ca % 2 == 1)       return 3'b100;
        if (cb % 2 == 1)       return 3'b010;
        return 3'b001;
    endfunction

    task automatic run_one(input logic [21:0] ma, input logic [21:0] mb,
                           input logic [15:0] d, input logic [3:0] ad,
                           input logic [2:0] ex, input string req);
        @(negedge clk);
        addr = ad; wr_data = d; inj_a = ma; inj_b = mb; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; inj_a = '0; inj_b = '0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2", "valid one edge after read", 32'(rd_valid), 32'd0);
        @(negedge clk);
        check("R2", "valid two edges after read", 32'(rd_valid), 32'd1);
        check(req, "sel_a", 32'(sel_a), 32'(ex[2]));
        check(req, "sel_b", 32'(sel_b), 32'(ex[1]));
        check(req, "uncorrectable", 32'(uncorrectable), 32'(ex[0]));
        if (!ex[0]) check(req, "rd_data", 32'(rd_data), 32'(d));
    endtask

    task automatic run_mask(input logic [43:0] m);
        logic [21:0] ma, mb;
        ma   = m[21:0];
        mb   = m[43:22];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pat++;
        // R1, R9: stored per-copy, any spread of up to three flips
        run_one(ma, mb, lfsr ^ 16'(pat), 4'(pat),
                predict($countones(ma), $countones(mb)), "R1,R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2", "reset rd_valid", 32'(rd_valid), 32'd0);
        check("R3", "reset selects", 32'({sel_a, sel_b, uncorrectable}), 32'd0);

        for (int n = 0; n < 8; n++) begin
            run_one(VEC[n][46:25], VEC[n][24:3], 16'h5A3C ^ 16'(n * 16'h1111),
                    4'(n), VEC[n][2:0], "R3-vector");
        end

        // R10: same-cycle read and write on one address
        run_one('0, '0, 16'hBEEF, 4'd9, 3'b100, "R10");
        @(negedge clk);
        addr = 4'd9; wr_data = 16'h1234; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        check("R10", "old word on collision", 32'(rd_data), 32'hBEEF);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check("R10", "new word afterwards", 32'(rd_data), 32'h1234);

        // R1: masks have no effect without a write
        @(negedge clk);
        inj_a = 22'h3FFFFF; inj_b = 22'h3FFFFF; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; inj_a = '0; inj_b = '0;
        @(negedge clk);
        check("R1", "mask ignored without write data", 32'(rd_data), 32'h1234);
        check("R1", "mask ignored without write sel_a", 32'(sel_a), 32'd1);

        // R9: every pattern of zero to three flips
        run_mask('0);
        for (int i = 0; i < 44; i++) begin
            logic [43:0] m;
            m = '0; m[i] = 1'b1;
            run_mask(m);
        end
        for (int i = 0; i < 44; i++) begin
            for (int j = i + 1; j < 44; j++) begin
                logic [43:0] m;
                m = '0; m[i] = 1'b1; m[j] = 1'b1;
                run_mask(m);
            end
        end
        for (int i = 0; i < 44; i++) begin
            for (int j = i + 1; j < 44; j++) begin
                for (int k = j + 1; k < 44; k++) begin
                    logic [43:0] m;
                    m = '0; m[i] = 1'b1; m[j] = 1'b1; m[k] = 1'b1;
                    run_mask(m);
                end
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule